// File: doc/BRIEF.md
# Butterfly Half-Adder Ones Counter

This block counts the ones in a data vector using nothing but half adders. The adders are wired as a butterfly. The first stage pairs raw input bits. Every later stage pairs sum bits only with sum bits and carry bits only with carry bits. Because of this, each final leaf of the network holds a flag whose weight is an exact power of two. The weight is two raised to the number of carry hops on the leaf's path. The block publishes these flags, sorted by weight, next to a binary count that adds them up with their weights. Typical users are distance-threshold circuits, for example comparing stored and incoming codewords after an XOR bank. Such circuits can often decide from a few flags without waiting for the full count.

The input width is a parameter. A width that is not a power of two is zero-extended to the next power of two, called the padded width, before the network sees it. The output can be purely combinational, or it can be captured in a register stage with asynchronous reset. The register stage is there for timing only.

Top module: `bfly_ones_count`

## Requirements
- R1: `count_o` is log2(padded width)+1 bits wide and equals the number of ones in `data_i` for every input value.
- R2: `flags_o` has one bit per padded input bit. With L = log2(padded width), the bits are grouped by ascending weight 2^p for p = 0..L. Group p holds C(L,p) bits and starts right after the groups of lower weight. The sum over all bits of bit value times group weight equals the number of ones in `data_i`.
- R3: Any set flag of weight w implies that `data_i` holds at least w ones.
- R4: Bit 0 of `flags_o` (weight 1) equals the parity (XOR) of `data_i`.
- R5: The top bit of `flags_o` (weight equal to the padded width) is set exactly when every padded input bit is one.
- R6: A non-power-of-two `WIDTH` is zero-extended to the padded width. The top flag therefore never sets, and the count never exceeds `WIDTH`.
- R7: With `REG_OUT` = 0, both outputs follow `data_i` with no clock edge in between.
- R8: With `REG_OUT` = 1, both outputs take the result for new data at the first rising `clk` edge after the data changes, and hold their earlier value until then.
- R9: With `REG_OUT` = 1, a low `rst_n` clears `count_o` and `flags_o` to zero at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register and for the checks |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_i | input | WIDTH | Vector whose ones are counted |
| flags_o | output | 2**ceil(log2(WIDTH)) | Power-of-two weighted flags, grouped by ascending weight |
| count_o | output | ceil(log2(WIDTH))+1 | Binary number of ones |

## Verification
The hardest flags to reach are the ones at the ends of the weight range. The top flag needs every padded bit set. The middle groups need input patterns whose carries travel down mixed sum/carry paths. On the wide instance these are reached with all-zero, all-one, walking-one, walking-zero and pseudo-random words. On the eight-bit instance every input value is applied, so every reachable flag combination occurs. The padded instance is swept through all of its values, including all-ones, to show that the top flag stays clear even when every real input bit is set.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

   // smallest r with 2**r >= v
   function automatic int unsigned log2c(input int unsigned v);
      int unsigned r;
      r = 0;
      while ((32'd1 << r) < v) r++;
      return r;
   endfunction

   function automatic int unsigned ones_of(input int unsigned v);
      int unsigned acc;
      acc = 0;
      for (int i = 0; i < 32; i++) acc += (v >> i) & 32'd1;
      return acc;
   endfunction

   function automatic int unsigned binom(input int unsigned n, input int unsigned k);
      int unsigned r;
      if (k > n) return 0;
      r = 1;
      for (int unsigned i = 1; i <= k; i++) r = r * (n - k + i) / i;
      return r;
   endfunction

   // first flag position of weight group p
   function automatic int unsigned group_base(input int unsigned lg, input int unsigned p);
      int unsigned acc;
      acc = 0;
      for (int unsigned q = 0; q < p; q++) acc += binom(lg, q);
      return acc;
   endfunction

   // output position of the leaf reached by path code (carry hops = ones)
   function automatic int unsigned sort_pos(input int unsigned lg, input int unsigned code);
      int unsigned p;
      int unsigned rank;
      p = ones_of(code);
      rank = 0;
      for (int unsigned j = 0; j < code; j++)
         if (ones_of(j) == p) rank++;
      return group_base(lg, p) + rank;
   endfunction

   // weight exponent of the flag at sorted position pos
   function automatic int unsigned group_of(input int unsigned lg, input int unsigned pos);
      int unsigned p;
      p = 0;
      while (p < lg && pos >= group_base(lg, p + 1)) p++;
      return p;
   endfunction

endpackage

// File: rtl/bfly_half_adder.sv
module bfly_half_adder (
   input  logic a_i,
   input  logic b_i,
   output logic s_o,
   output logic c_o
);
   assign s_o = a_i ^ b_i;
   assign c_o = a_i & b_i;
endmodule

// File: rtl/bfly_stage.sv
module bfly_stage #(
   parameter int unsigned PAD_W = 8,
   parameter int unsigned STAGE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PAD_W-1:0] din,
   output logic [PAD_W-1:0] dout
);
   import bfly_pkg::*;

   localparam int unsigned NB   = 1 << STAGE;
   localparam int unsigned BLK  = PAD_W >> STAGE;
   localparam int unsigned HALF = BLK / 2;

   if (BLK < 2) begin : g_bad_stage
      $error("bfly_stage: stage index leaves fewer than two bits per block");
   end

   // block b splits into sum block 2b and carry block 2b+1
   for (genvar b = 0; b < NB; b++) begin : g_blk
      for (genvar j = 0; j < HALF; j++) begin : g_ha
         bfly_half_adder u_ha (
            .a_i (din[b*BLK + j]),
            .b_i (din[b*BLK + j + HALF]),
            .s_o (dout[(2*b)*HALF + j]),
            .c_o (dout[(2*b+1)*HALF + j])
         );
      end
   end

   function automatic int unsigned wsum(input logic [PAD_W-1:0] v, input int unsigned blk);
      int unsigned acc;
      acc = 0;
      for (int unsigned i = 0; i < PAD_W; i++)
         if (v[i]) acc += 32'd1 << ones_of(i / blk);
      return acc;
   endfunction

   int unsigned w_in, w_out;
   always_comb begin
      w_in  = wsum(din, BLK);
      w_out = wsum(dout, HALF);
   end

   // R2
   stage_conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
      w_out == w_in);

endmodule

// File: rtl/bfly_network.sv
module bfly_network #(
   parameter int unsigned PAD_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PAD_W-1:0] din,
   output logic [PAD_W-1:0] leaves
);
   import bfly_pkg::*;

   localparam int unsigned LG = log2c(PAD_W);

   logic [PAD_W-1:0] lvl [LG+1];

   assign lvl[0] = din;

   for (genvar s = 0; s < LG; s++) begin : g_stage
      bfly_stage #(.PAD_W(PAD_W), .STAGE(s)) u_stage (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (lvl[s]),
         .dout (lvl[s+1])
      );
   end

   assign leaves = lvl[LG];
endmodule

// File: rtl/bfly_reduce.sv
module bfly_reduce #(
   parameter int unsigned PAD_W = 8,
   parameter int unsigned CNT_W = 4
) (
   input  logic [PAD_W-1:0] leaves,
   output logic [PAD_W-1:0] flags,
   output logic [CNT_W-1:0] count
);
   import bfly_pkg::*;

   localparam int unsigned LG = log2c(PAD_W);

   if (CNT_W != LG + 1) begin : g_bad_cnt
      $error("bfly_reduce: count width must be log2(PAD_W)+1");
   end

   logic [CNT_W-1:0] term [PAD_W];

   for (genvar k = 0; k < PAD_W; k++) begin : g_leaf
      localparam int unsigned POS = sort_pos(LG, k);
      localparam int unsigned WEX = ones_of(k);
      assign flags[POS] = leaves[k];
      assign term[k]    = leaves[k] ? (CNT_W'(1) << WEX) : '0;
   end

   always_comb begin
      count = '0;
      for (int k = 0; k < int'(PAD_W); k++) count = count + term[k];
   end
endmodule

// File: rtl/bfly_ones_count.sv
module bfly_ones_count #(
   parameter int unsigned WIDTH   = 64,
   parameter bit          REG_OUT = 1'b0,
   localparam int unsigned LG     = bfly_pkg::log2c(WIDTH),
   localparam int unsigned PAD_W  = 1 << LG,
   localparam int unsigned CNT_W  = LG + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] data_i,
   output logic [PAD_W-1:0] flags_o,
   output logic [CNT_W-1:0] count_o
);
   import bfly_pkg::*;

   if (WIDTH < 2) begin : g_bad_min
      $error("bfly_ones_count: WIDTH must be at least 2");
   end
   if (WIDTH > 4096) begin : g_bad_max
      $error("bfly_ones_count: WIDTH above 4096 is not supported");
   end

   logic [PAD_W-1:0] pad;
   logic [PAD_W-1:0] leaves;
   logic [PAD_W-1:0] flags_c;
   logic [CNT_W-1:0] cnt_c;

   if (PAD_W == WIDTH) begin : g_nopad
      assign pad = data_i;
   end else begin : g_pad
      assign pad = {{(PAD_W-WIDTH){1'b0}}, data_i};
   end

   bfly_network #(.PAD_W(PAD_W)) u_net (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pad),
      .leaves(leaves)
   );

   bfly_reduce #(.PAD_W(PAD_W), .CNT_W(CNT_W)) u_red (
      .leaves(leaves),
      .flags (flags_c),
      .count (cnt_c)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flags_o <= '0;
            count_o <= '0;
         end else begin
            flags_o <= flags_c;
            count_o <= cnt_c;
         end
      end

      // R8
      reg_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> (count_o == $past(cnt_c) && flags_o == $past(flags_c)));
   end else begin : g_comb
      assign flags_o = flags_c;
      assign count_o = cnt_c;
   end

   // R1
   count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt_c) == $countones(data_i));

   // R4
   parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags_c[0] == ^data_i);

   // R5
   top_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags_c[PAD_W-1] == (&pad));

   for (genvar i = 0; i < PAD_W; i++) begin : g_bound
      localparam int unsigned GP = group_of(LG, i);
      // R3
      weight_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
         flags_c[i] |-> ($countones(data_i) >= (1 << GP)));
   end

endmodule

// File: tb/bfly_ones_count_tb.sv
module bfly_ones_count_tb;

   logic clk   = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [7:0]  d8  = '0;
   logic [7:0]  f8;
   logic [3:0]  c8;
   logic [63:0] d64 = '1;
   logic [63:0] f64;
   logic [6:0]  c64;
   logic [5:0]  d6  = '0;
   logic [7:0]  f6;
   logic [3:0]  c6;

   bfly_ones_count #(.WIDTH(8), .REG_OUT(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .data_i(d8), .flags_o(f8), .count_o(c8));
   bfly_ones_count #(.WIDTH(64), .REG_OUT(1'b1)) u_dut_w64 (
      .clk(clk), .rst_n(rst_n), .data_i(d64), .flags_o(f64), .count_o(c64));
   bfly_ones_count #(.WIDTH(6), .REG_OUT(1'b0)) u_dut_w6 (
      .clk(clk), .rst_n(rst_n), .data_i(d6), .flags_o(f6), .count_o(c6));

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int binom(input int n, input int k);
      int r = 1;
      for (int i = 1; i <= k; i++) r = r * (n - k + i) / i;
      return r;
   endfunction

   // weight exponent of sorted position pos, from the group sizes in R2
   function automatic int grp(input int pos, input int lg);
      int base = 0;
      for (int p = 0; p <= lg; p++) begin
         base += binom(lg, p);
         if (pos < base) return p;
      end
      return lg;
   endfunction

   // R2, R3, R4, R5 on one flag vector
   task automatic check_flags(input logic [63:0] fl, input int n, input int lg,
                              input int ones, input bit par, input bit full);
      int wsum = 0;
      for (int i = 0; i < n; i++) begin
         if (fl[i]) begin
            wsum += 1 << grp(i, lg);
            chk(ones >= (1 << grp(i, lg)), "R3", ones, 1 << grp(i, lg));
         end
      end
      chk(wsum == ones, "R2", wsum, ones);
      chk(fl[0] == par, "R4", fl[0], par);
      chk(fl[n-1] == full, "R5", fl[n-1], full);
   endtask

   task automatic test_reset;
      repeat (2) @(posedge clk);
      #1;
      chk(c64 == '0, "R9", c64, 0);
      chk(f64 == '0, "R9", f64, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk(int'(c64) == 64, "R8", c64, 64);
      // asynchronous clear mid-run
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk(c64 == '0, "R9", c64, 0);
      chk(f64 == '0, "R9", f64, 0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic test_exhaustive8;
      for (int v = 0; v < 256; v++) begin
         @(posedge clk);
         #2;
         d8 = 8'(v);
         #1;
         chk(int'(c8) == $countones(d8), "R1 R7", c8, $countones(d8));
         check_flags({56'd0, f8}, 8, 3, $countones(d8), ^d8, &d8);
      end
   endtask

   task automatic apply64(input logic [63:0] v);
      logic [6:0] old;
      @(negedge clk);
      old = c64;
      d64 = v;
      #1;
      chk(c64 == old, "R8", c64, old);
      @(posedge clk);
      #1;
      chk(int'(c64) == $countones(v), "R1", c64, $countones(v));
      check_flags(f64, 64, 6, $countones(v), ^v, &v);
   endtask

   task automatic test_w64;
      logic [63:0] r;
      apply64('0);
      apply64('1);
      for (int i = 0; i < 64; i += 7) apply64(64'd1 << i);
      for (int i = 0; i < 64; i += 9) apply64(~(64'd1 << i));
      apply64(64'hAAAA_AAAA_AAAA_AAAA);
      apply64(64'h0000_FFFF_0000_FFFF);
      for (int i = 0; i < 200; i++) begin
         r = {$urandom(), $urandom()};
         apply64(r);
      end
      apply64('1);
   endtask

   task automatic test_pad6;
      for (int v = 0; v < 64; v++) begin
         @(posedge clk);
         #2;
         d6 = 6'(v);
         #1;
         chk(int'(c6) == $countones(d6), "R1 R6", c6, $countones(d6));
         chk(f6[7] == 1'b0, "R6", f6[7], 0);
         check_flags({56'd0, f6}, 8, 3, $countones(d6), ^d6, 1'b0);
      end
   endtask

   initial begin
      void'($urandom(32'h5EED));
      test_reset;
      test_exhaustive8;
      test_w64;
      test_pad6;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule